// File: doc/BRIEF.md
# Double-Buffered SPI Shift Engine

This block moves bytes between a processor-side register port and a four-wire SPI bus. It works as either bus master or bus slave. A one-byte holding register sits in front of the 8-bit shifter. Software can queue the next byte while the current one is still on the wire, so consecutive bytes leave with no idle clock between them. A transmit-empty flag shows when the holding register can take another byte. Each completed byte is latched into a read register, and a receive-full flag is raised.

As master, the block makes SCK from the system clock through a programmable divider. It drives slave select low for as long as it is streaming. As slave, it follows an external SCK and an external select, both brought in through two-stage synchronizers. When no new byte has been queued by the start of the next byte, the slave sends back the byte it has just received. The bus runs in mode 0 only: SCK idles low, data is sampled on the rising edge and changed on the falling edge, and the most significant bit goes first.

Top module: `spi_dbuf_engine`

## Requirements
- R1: `tx_empty` is 1 after reset and whenever the holding register is free. A write (`wr_en` high while `tx_empty` is 1) makes `tx_empty` 0 in the next cycle.
- R2: In master mode with the shifter idle, a queued byte moves into the shifter one cycle after it is written. In that same cycle `tx_empty` returns to 1, `ss_n_out` goes low, and `sck_out` is still low.
- R3: In master mode each SCK half period lasts `clk_div`+1 system clocks. SCK idles low, and `mosi_out` does not change while `sck_out` is high.
- R4: Bytes are shifted most significant bit first, both out of the shifter and into the receive byte.
- R5: A byte queued before the current byte's last falling SCK edge is loaded at that edge. The spacing between rising SCK edges then stays exactly 2×(`clk_div`+1) clocks across the byte boundary.
- R6: If the holding register is empty at the end of a byte in master mode, clocking stops. `sck_out` stays low and `ss_n_out` returns high.
- R7: On the 8th rising SCK edge of a byte, the received byte is latched into `rd_data` and `rx_full` is set. A pulse on `rd_en` clears `rx_full`.
- R8: A write while `tx_empty` is 0 is dropped and the queued byte is kept. It sets `wr_coll`, which stays at 1 until reset.
- R9: In slave mode (`is_master` = 0), the block samples `mosi_in` on the synchronized rising edges of `sck_in` while `ss_n_in` is low. It presents its transmit byte on `miso_out`, MSB first. A byte queued while deselected is the first one sent.
- R10: In slave mode, if the holding register is empty when a byte ends, the next byte sent on `miso_out` is the byte just received.
- R11: In slave mode, raising `ss_n_in` resets the bit counter. After reselection, 8 fresh SCK cycles form one complete received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| is_master | input | 1 | 1 selects master mode, 0 selects slave mode |
| clk_div | input | DIV_W | Divider value N; SCK half period is N+1 clocks |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| tx_empty | output | 1 | Holding register is free |
| wr_coll | output | 1 | Sticky flag: a write arrived while the holding register was full |
| rd_en | input | 1 | Read strobe; clears `rx_full` |
| rd_data | output | 8 | Last complete received byte |
| rx_full | output | 1 | A byte has been received since the last read |
| sck_out | output | 1 | Master serial clock |
| ss_n_out | output | 1 | Master slave select, active low |
| mosi_out | output | 1 | Master serial data out |
| miso_in | input | 1 | Master serial data in |
| sck_in | input | 1 | Slave serial clock from external master |
| ss_n_in | input | 1 | Slave select from external master, active low |
| mosi_in | input | 1 | Slave serial data in |
| miso_out | output | 1 | Slave serial data out |

## Verification
The bench builds the engine with `DIV_W` = 4 and drives `clk_div` at run time with 0, 1, 2 and 3. These values cover the fastest SCK, at two clocks per period, and slower ratios where a byte boundary falls at different points in the divider count. The same gap check therefore holds at every ratio. The slave half period is set to 8 system clocks, which leaves room for the two-stage synchronizer. With that margin, the resend-on-empty case and a deselect in the middle of a byte can both be run to completion.

// File: rtl/spi_dbuf_engine.sv
module spi_dbuf_engine #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             is_master,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic             tx_empty,
  output logic             wr_coll,
  input  logic             rd_en,
  output logic [7:0]       rd_data,
  output logic             rx_full,
  output logic             sck_out,
  output logic             ss_n_out,
  output logic             mosi_out,
  input  logic             miso_in,
  input  logic             sck_in,
  input  logic             ss_n_in,
  input  logic             mosi_in,
  output logic             miso_out
);
  logic [7:0]       hold_q, shf_q;
  logic             lat_q, act_q, sck_q;
  logic [2:0]       bit_q;
  logic [DIV_W-1:0] cnt_q;
  logic [2:0]       sck_sy;
  logic [1:0]       ss_sy;

  wire ss_s    = ss_sy[1];
  wire slv_sel = !is_master && !ss_s;
  wire m_tick  = act_q && (cnt_q == clk_div);
  wire rise_ev = is_master ? (m_tick && !sck_q) : (slv_sel && sck_sy[1] && !sck_sy[2]);
  wire fall_ev = is_master ? (m_tick && sck_q)  : (slv_sel && !sck_sy[1] && sck_sy[2]);
  wire byte_end = fall_ev && (bit_q == 3'd7);
  wire m_start  = is_master && !act_q && !tx_empty;
  wire s_load   = !is_master && ss_s && !tx_empty;
  wire take     = m_start || s_load || (byte_end && !tx_empty);
  wire ser_in   = is_master ? miso_in : mosi_in;

  assign sck_out  = sck_q;
  assign ss_n_out = !(is_master && act_q);
  assign mosi_out = is_master ? shf_q[7] : 1'b0;
  assign miso_out = shf_q[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy <= '0;
      ss_sy  <= 2'b11;
    end else begin
      sck_sy <= {sck_sy[1:0], sck_in};
      ss_sy  <= {ss_sy[0], ss_n_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      tx_empty <= 1'b1;
      wr_coll  <= 1'b0;
    end else begin
      if (take) tx_empty <= 1'b1;
      if (wr_en && tx_empty) begin
        hold_q   <= wr_data;
        tx_empty <= 1'b0;
      end
      if (wr_en && !tx_empty) wr_coll <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shf_q <= '0;
      lat_q <= 1'b0;
      bit_q <= '0;
    end else begin
      if (take)         shf_q <= hold_q;
      else if (fall_ev) shf_q <= {shf_q[6:0], lat_q};
      if (rise_ev) lat_q <= ser_in;
      if ((!is_master && ss_s) || (is_master && !act_q)) bit_q <= '0;
      else if (fall_ev) bit_q <= bit_q + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      sck_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (!is_master)                          act_q <= 1'b0;
      else if (m_start)                        act_q <= 1'b1;
      else if (byte_end && tx_empty)           act_q <= 1'b0;
      cnt_q <= (!act_q || m_tick) ? '0 : cnt_q + 1'b1;
      if (!act_q)      sck_q <= 1'b0;
      else if (m_tick) sck_q <= ~sck_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      rx_full <= 1'b0;
    end else if (rise_ev && bit_q == 3'd7) begin
      rd_data <= {shf_q[6:0], ser_in};
      rx_full <= 1'b1;
    end else if (rd_en) begin
      rx_full <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_dbuf_engine_chk.sv
module spi_dbuf_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic is_master,
  input logic wr_en,
  input logic tx_empty,
  input logic wr_coll,
  input logic sck_out,
  input logic ss_n_out,
  input logic mosi_out
);
  a_r1_write_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && tx_empty |=> !tx_empty);
  a_r8_collision_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !tx_empty |=> wr_coll);
  a_r8_collision_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wr_coll |=> wr_coll);
  a_r3_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    is_master && sck_out && $past(sck_out) && $past(is_master) |-> $stable(mosi_out));
  a_r6_sck_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n_out |-> !sck_out);
endmodule

bind spi_dbuf_engine spi_dbuf_engine_chk u_chk (.*);

// File: tb/sim_spi_dbuf_engine.sv
module sim_spi_dbuf_engine;
  localparam int CLK_P = 10;
  localparam int SH = 8;
  localparam logic [39:0] VEC [4] = '{
    {8'd0, 8'hC3, 8'h5E, 8'h17, 8'hE8},
    {8'd1, 8'h01, 8'h80, 8'hFF, 8'h00},
    {8'd3, 8'hA6, 8'h6A, 8'h39, 8'h93},
    {8'd2, 8'h7F, 8'hFE, 8'h42, 8'hBD}
  };

  logic clk = 0, rst_n = 0, is_master = 1, wr_en = 0, rd_en = 0;
  logic [3:0] clk_div = 1;
  logic [7:0] wr_data = 0, rd_data;
  logic tx_empty, wr_coll, rx_full, sck_out, ss_n_out, mosi_out, miso_out;
  logic sck_in = 0, ss_n_in = 1, mosi_in = 0;
  logic [15:0] pshift = 0, mon = 0;
  wire miso_in = pshift[15];
  int nchk = 0, nfail = 0, rises = 0, gap_bad = 0, run = 0, cyc = 0, last_rise = 0;
  logic prev_sck = 0;

  always #(CLK_P/2) clk = ~clk;

  spi_dbuf_engine #(.DIV_W(4)) u0 (.*);

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (ss_n_out) run <= 0;
    if (sck_out && !prev_sck) begin
      rises <= rises + 1;
      mon <= {mon[14:0], mosi_out};
      if (run > 0 && cyc - last_rise != 2 * (int'(clk_div) + 1)) gap_bad <= gap_bad + 1;
      last_rise <= cyc;
      run <= run + 1;
    end
    if (!sck_out && prev_sck) pshift <= pshift << 1;
    prev_sck <= sck_out;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); wr_en = 1; wr_data = b;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_done;
    @(negedge clk);
    while (ss_n_out) @(negedge clk);
    while (!ss_n_out) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic slave_byte(input logic [7:0] mo, output logic [7:0] got);
    for (int i = 7; i >= 0; i--) begin
      mosi_in = mo[i];
      repeat (SH) @(negedge clk);
      sck_in = 1; got[i] = miso_out;
      repeat (SH) @(negedge clk);
      sck_in = 0;
    end
    repeat (SH) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [7:0] got;
    repeat (3) @(negedge clk);
    chk(tx_empty && !rx_full && !wr_coll && !sck_out && ss_n_out, "R1 reset",
        {tx_empty, rx_full, wr_coll, sck_out, ss_n_out}, 5'b10001);
    rst_n = 1;
    repeat (2) @(negedge clk);

    foreach (VEC[k]) begin
      clk_div = VEC[k][35:32];
      pshift = VEC[k][15:0];
      rises = 0;
      wr(VEC[k][31:24]);
      wr(VEC[k][23:16]);
      wait_done;
      chk(mon == VEC[k][31:16], "R4 mosi bytes", mon, VEC[k][31:16]);
      chk(rises == 16 && gap_bad == 0, "R5 zero gap", gap_bad, 0);
      chk(rd_data == VEC[k][7:0] && rx_full, "R7 rx byte", rd_data, VEC[k][7:0]);
      @(negedge clk); rd_en = 1; @(negedge clk); rd_en = 0;
      chk(!rx_full, "R7 read clears", rx_full, 0);
    end

    clk_div = 1; rises = 0; pshift = 16'h2D00;
    @(negedge clk); wr_en = 1; wr_data = 8'h96;
    @(negedge clk); wr_en = 0;
    chk(!tx_empty, "R1 write clears empty", tx_empty, 0);
    @(negedge clk);
    chk(tx_empty && !ss_n_out && !sck_out, "R2 load on idle",
        {tx_empty, ss_n_out, sck_out}, 3'b100);
    repeat (2) @(negedge clk);
    chk(sck_out, "R3 half period N+1", sck_out, 1);
    repeat (2) @(negedge clk);
    chk(!sck_out, "R3 low after N+1", sck_out, 0);
    wait_done;
    chk(mon[7:0] == 8'h96 && rises == 8, "R4 single byte", mon[7:0], 8'h96);
    repeat (20) @(negedge clk);
    chk(rises == 8 && ss_n_out && !sck_out, "R6 stop when empty", rises, 8);
    chk(rd_data == 8'h2D, "R4 miso msb first", rd_data, 8'h2D);

    rises = 0;
    wr(8'h11); wr(8'h22); wr(8'h33);
    chk(wr_coll, "R8 collision flag", wr_coll, 1);
    wait_done;
    chk(mon == 16'h1122 && rises == 16, "R8 dropped write", mon, 16'h1122);
    chk(wr_coll, "R8 sticky", wr_coll, 1);

    is_master = 0;
    repeat (4) @(negedge clk);
    wr(8'hA5);
    repeat (4) @(negedge clk);
    ss_n_in = 0;
    repeat (SH) @(negedge clk);
    slave_byte(8'h3C, got);
    chk(got == 8'hA5, "R9 slave miso", got, 8'hA5);
    chk(rd_data == 8'h3C && rx_full, "R9 slave rx", rd_data, 8'h3C);
    slave_byte(8'h81, got);
    chk(got == 8'h3C, "R10 resend last rx", got, 8'h3C);
    chk(rd_data == 8'h81, "R9 second rx", rd_data, 8'h81);
    for (int i = 0; i < 3; i++) begin
      mosi_in = 1; repeat (SH) @(negedge clk);
      sck_in = 1; repeat (SH) @(negedge clk);
      sck_in = 0;
    end
    repeat (SH) @(negedge clk);
    ss_n_in = 1;
    repeat (SH) @(negedge clk);
    ss_n_in = 0;
    repeat (SH) @(negedge clk);
    slave_byte(8'h4B, got);
    chk(rd_data == 8'h4B, "R11 deselect resets count", rd_data, 8'h4B);
    ss_n_in = 1;

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule